// File: doc/BRIEF.md
# Slow-Bus Synchronization Stall Unit

This block sits between a fast processor core and a slow host bus clocked at 1 MHz. For every access the core presents, it decides in the same cycle whether the access may finish at full speed, or whether the core must be held until the host bus reaches its next 1 MHz phase. The decision depends on the 16-bit address, the direction of the access and whether the machine runs in 64 or 128 mode. Colour RAM writes are also held while the write buffer is still busy.

The block also guards the two video-controller ports. After a port access has been granted, further port accesses are refused until the end of the following whole 1 MHz cycle. A status output shows this lockout. The control FSM has three states. IDLE judges each new request. SYNC_WAIT holds an access until a qualifying phase strobe. DRAIN_WAIT holds a colour RAM write until the buffer is free. The transitions are IDLE->SYNC_WAIT on a request that needs a strobe or hits the lockout, IDLE->DRAIN_WAIT on a colour write with the buffer busy, and either wait state ->IDLE on grant or when the request is dropped. The lockout tracker has three states: LK_OFF, LK_TAIL (the rest of the current 1 MHz cycle) and LK_HOLD (the following whole cycle). A strobe moves LK_TAIL to LK_HOLD and LK_HOLD to LK_OFF. A port grant loads LK_TAIL, or LK_HOLD if the grant falls on a strobe.

Top module: `slowbus_stall_unit`

## Requirements
- R1: While reset is asserted and after it is released, `vdc_lockout` is 0 and the FSM is in IDLE, so `acc_ready` is 0 whenever `acc_req` is 0.
- R2: In 128 mode (`mode_128`=1), reads and writes of 0x0001 and 0xFF00 are not granted in the request cycle. `acc_ready` rises in the first cycle after the request cycle in which `phi_stb`=1. A strobe in the request cycle itself does not count.
- R3: In 128 mode, reads of 0xD600, 0xD601 and 0xFF01 to 0xFF04 stall as in R2. Writes to 0xFF01 to 0xFF04 are granted in the request cycle. 0xFF05 and 0xD602 are full speed.
- R4: In 64 mode (`mode_128`=0), accesses to 0x0001, 0xFF00 to 0xFF04 and 0xD600/0xD601 are granted in the request cycle and never raise `vdc_lockout`.
- R5: Accesses to 0xD070 to 0xD07F, 0xD0B0 to 0xD0BF, 0xD200 to 0xD3FF and any address not named in R2 to R6 are granted in the request cycle in both modes.
- R6: Colour RAM (0xD800 to 0xDBFF) reads are granted in the request cycle. Writes are granted in the first cycle, counting the request cycle, in which `wbuf_busy`=0.
- R7: A granted 128-mode access to 0xD600 or 0xD601 raises `vdc_lockout` from the next cycle. If the grant came without a strobe, the lockout stays up through the next strobe cycle and the following strobe cycle, and drops after the second one. A grant that falls on a strobe drops after the next strobe.
- R8: While `vdc_lockout`=1, a 128-mode access to 0xD600 or 0xD601 (read or write) is granted only in the strobe cycle that ends the lockout. Other addresses are unaffected by the lockout.
- R9: Dropping `acc_req` while stalled abandons the access with `acc_ready`=0, and the next request is judged afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_req | input | 1 | Core access request, held until granted |
| acc_addr | input | ADDR_W (16) | Access address |
| acc_wr | input | 1 | 1 = write, 0 = read |
| mode_128 | input | 1 | 1 = 128 mode, 0 = 64 mode |
| phi_stb | input | 1 | One-cycle pulse marking the 1 MHz phase edge |
| wbuf_busy | input | 1 | Write buffer still has a pending operation |
| acc_ready | output | 1 | Access completes in this cycle |
| vdc_lockout | output | 1 | Video-controller port lockout active |

## Verification
The hardest situation to reach is a port access that arrives while the lockout is still in its first part. It must pass up one strobe and be granted only at the second one, and that grant must then start a fresh lockout. The stimulus reaches this in three steps. A port write is granted with no strobe present. A port read follows at once. The strobes are then placed by hand, so the refusal at the first strobe, the grant at the second and the restarted lockout can all be sampled. The same is done for a port write issued during the second part of the lockout, and for an ordinary access during a lockout to show that the lockout does not touch it.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_SYNC_WAIT  = 2'd1,
        ST_DRAIN_WAIT = 2'd2
    } ctl_state_t;

    typedef enum logic [1:0] {
        LK_OFF  = 2'd0,
        LK_TAIL = 2'd1,
        LK_HOLD = 2'd2
    } lock_state_t;

    // mode-qualified address class of one access
    typedef struct packed {
        logic sync_any;   // stall for reads and writes
        logic sync_rd;    // stall for reads only
        logic vdc_port;   // video-controller port hit
        logic colour;     // colour RAM window
    } acc_class_t;

endpackage

// File: rtl/sbs_addr_class.sv
module sbs_addr_class
    import sbs_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int PORT_ADDR   = 'h0001,
    parameter int MMU_CFG     = 'hFF00,
    parameter int MMU_PRE_LO  = 'hFF01,
    parameter int MMU_PRE_HI  = 'hFF04,
    parameter int VDC_BASE    = 'hD600,
    parameter int VDC_PORTS   = 2,
    parameter int COLR_LO     = 'hD800,
    parameter int COLR_HI     = 'hDBFF
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              mode_128,
    output acc_class_t        cls
);
    localparam logic [ADDR_W-1:0] A_PORT   = ADDR_W'(PORT_ADDR);
    localparam logic [ADDR_W-1:0] A_CFG    = ADDR_W'(MMU_CFG);
    localparam logic [ADDR_W-1:0] A_PRE_LO = ADDR_W'(MMU_PRE_LO);
    localparam logic [ADDR_W-1:0] A_PRE_HI = ADDR_W'(MMU_PRE_HI);
    localparam logic [ADDR_W-1:0] A_COL_LO = ADDR_W'(COLR_LO);
    localparam logic [ADDR_W-1:0] A_COL_HI = ADDR_W'(COLR_HI);

    logic [VDC_PORTS-1:0] port_hit;

    generate
        for (genvar gi = 0; gi < VDC_PORTS; gi++) begin : g_port
            localparam logic [ADDR_W-1:0] A_P = ADDR_W'(VDC_BASE + gi);
            assign port_hit[gi] = (addr == A_P);
        end
    endgenerate

    logic pre_hit;
    assign pre_hit = (addr >= A_PRE_LO) && (addr <= A_PRE_HI);

    always_comb begin
        cls.sync_any = mode_128 && ((addr == A_PORT) || (addr == A_CFG));
        cls.vdc_port = mode_128 && (|port_hit);
        cls.sync_rd  = mode_128 && ((|port_hit) || pre_hit);
        cls.colour   = (addr >= A_COL_LO) && (addr <= A_COL_HI);
    end

endmodule

// File: rtl/sbs_vdc_lockout.sv
module sbs_vdc_lockout
    import sbs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        phi_stb,
    input  logic        port_grant,
    output lock_state_t lock_q
);
    lock_state_t lock_d;

    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= LK_OFF;
        else        lock_q <= lock_d;
    end

    always_comb begin
        lock_d = lock_q;
        if (port_grant) begin
            lock_d = phi_stb ? LK_HOLD : LK_TAIL;
        end else if (phi_stb) begin
            unique case (lock_q)
                LK_OFF:  lock_d = LK_OFF;
                LK_TAIL: lock_d = LK_HOLD;
                LK_HOLD: lock_d = LK_OFF;
                default: lock_d = LK_OFF;
            endcase
        end
    end

    // R7: without a port grant the lockout never appears from nothing
    p_quiet_stays_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q == LK_OFF && !port_grant) |=> (lock_q == LK_OFF));

    // R7: the first part of the lockout is left only on a strobe or a new grant
    p_tail_needs_stb_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q == LK_TAIL && !phi_stb && !port_grant) |=> (lock_q == LK_TAIL));

endmodule

// File: rtl/slowbus_stall_unit.sv
module slowbus_stall_unit
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_wr,
    input  logic              mode_128,
    input  logic              phi_stb,
    input  logic              wbuf_busy,
    output logic              acc_ready,
    output logic              vdc_lockout
);
    ctl_state_t  state_q, state_d;
    lock_state_t lock_q;
    acc_class_t  cls;

    logic need_sync, need_drain, port_grant, tail_block;

    sbs_addr_class #(.ADDR_W(ADDR_W)) u_class (
        .addr     (acc_addr),
        .mode_128 (mode_128),
        .cls      (cls)
    );

    sbs_vdc_lockout u_lock (
        .clk        (clk),
        .rst_n      (rst_n),
        .phi_stb    (phi_stb),
        .port_grant (port_grant),
        .lock_q     (lock_q)
    );

    // request classification
    always_comb begin
        need_sync  = cls.sync_any || (cls.sync_rd && !acc_wr) ||
                     (cls.vdc_port && lock_q != LK_OFF);
        need_drain = cls.colour && acc_wr && wbuf_busy;
        tail_block = cls.vdc_port && (lock_q == LK_TAIL);
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (acc_req && need_sync)       state_d = ST_SYNC_WAIT;
                else if (acc_req && need_drain) state_d = ST_DRAIN_WAIT;
            end
            ST_SYNC_WAIT: begin
                if (!acc_req || acc_ready) state_d = ST_IDLE;
            end
            ST_DRAIN_WAIT: begin
                if (!acc_req || acc_ready) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        acc_ready = 1'b0;
        unique case (state_q)
            ST_IDLE:       acc_ready = acc_req && !need_sync && !need_drain;
            ST_SYNC_WAIT:  acc_ready = acc_req && phi_stb && !tail_block;
            ST_DRAIN_WAIT: acc_ready = acc_req && !wbuf_busy;
            default:       acc_ready = 1'b0;
        endcase
        port_grant  = acc_ready && cls.vdc_port;
        vdc_lockout = (lock_q != LK_OFF);
    end

    // R2: a slow-class request is never granted in its first cycle
    p_slow_not_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && acc_req && cls.sync_any) |-> !acc_ready);

    // R6: no colour RAM write completes while the buffer is busy
    p_colour_waits_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_wr && cls.colour && wbuf_busy) |-> !acc_ready);

    // R7: a granted port access always leaves the lockout raised
    p_grant_locks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ready && cls.vdc_port) |=> vdc_lockout);

    // R8: no port access gets through during the first part of the lockout
    p_tail_blocks_port_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cls.vdc_port && lock_q == LK_TAIL) |-> !acc_ready);

    // R9: a dropped request returns the controller to IDLE
    p_drop_to_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !acc_req) |=> (state_q == ST_IDLE));

endmodule

// File: tb/sim_slowbus_stall_unit.sv
module sim_slowbus_stall_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req = 1'b0;
    logic [15:0] acc_addr = 16'h0;
    logic        acc_wr = 1'b0;
    logic        mode_128 = 1'b0;
    logic        phi_stb = 1'b0;
    logic        wbuf_busy = 1'b0;
    logic        acc_ready;
    logic        vdc_lockout;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    slowbus_stall_unit u0 (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_addr(acc_addr),
        .acc_wr(acc_wr), .mode_128(mode_128), .phi_stb(phi_stb),
        .wbuf_busy(wbuf_busy), .acc_ready(acc_ready), .vdc_lockout(vdc_lockout)
    );

    // {req tag, mode_128, wr, wbuf_busy, expected ready, address}
    localparam int NV = 18;
    localparam logic [23:0] VEC [NV] = '{
        {4'd2, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0001},  // R2
        {4'd2, 1'b1, 1'b1, 1'b0, 1'b0, 16'hFF00},  // R2
        {4'd3, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFF03},  // R3
        {4'd3, 1'b1, 1'b0, 1'b0, 1'b0, 16'hD601},  // R3
        {4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFF04},  // R3
        {4'd3, 1'b1, 1'b1, 1'b0, 1'b1, 16'hFF01},  // R3
        {4'd3, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFF05},  // R3 boundary
        {4'd3, 1'b1, 1'b0, 1'b0, 1'b1, 16'hD602},  // R3 boundary
        {4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 16'h0001},  // R4
        {4'd4, 1'b0, 1'b0, 1'b0, 1'b1, 16'hFF00},  // R4
        {4'd4, 1'b0, 1'b1, 1'b0, 1'b1, 16'hD600},  // R4
        {4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 16'hD07C},  // R5
        {4'd5, 1'b1, 1'b0, 1'b0, 1'b1, 16'hD0BF},  // R5
        {4'd5, 1'b0, 1'b0, 1'b0, 1'b1, 16'hD2FF},  // R5
        {4'd5, 1'b1, 1'b1, 1'b0, 1'b1, 16'hD3FF},  // R5
        {4'd6, 1'b1, 1'b0, 1'b1, 1'b1, 16'hDA00},  // R6
        {4'd6, 1'b0, 1'b1, 1'b1, 1'b0, 16'hD800},  // R6
        {4'd6, 1'b1, 1'b1, 1'b0, 1'b1, 16'hDBFF}   // R6
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    // drive at the falling edge, settle before the next rising edge
    task automatic step(input logic rq, input logic m, input logic w,
                        input logic [15:0] a, input logic b, input logic ph);
        @(negedge clk);
        acc_req = rq; mode_128 = m; acc_wr = w; acc_addr = a;
        wbuf_busy = b; phi_stb = ph;
        #2;
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(0, 0, 0, 16'h0, 0, 0);
        chk(vdc_lockout, 1'b0, "R1 lockout in reset");
        chk(acc_ready, 1'b0, "R1 ready in reset");
        step(0, 0, 0, 16'h0, 0, 0);
        rst_n = 1'b1;
        step(0, 0, 0, 16'h0, 0, 0);
        chk(vdc_lockout, 1'b0, "R1 lockout after reset");
        chk(acc_ready, 1'b0, "R1 ready after reset");

        // table walk: first-cycle verdict, strobe held low
        for (int i = 0; i < NV; i++) begin
            step(1'b1, VEC[i][19], VEC[i][18], VEC[i][15:0], VEC[i][17], 1'b0);
            n_chk++;
            if (acc_ready !== VEC[i][16]) begin
                n_bad++;
                $display("FAIL R%0d addr %h: actual %b expected %b",
                         VEC[i][23:20], VEC[i][15:0], acc_ready, VEC[i][16]);
            end
            step(0, 0, 0, 16'h0, 0, 0);
        end
        chk(vdc_lockout, 1'b0, "R4 no lockout from 64-mode port access");

        // R2: strobe in request cycle does not count
        step(1, 1, 0, 16'h0001, 0, 1);
        chk(acc_ready, 1'b0, "R2 strobe in request cycle");
        step(1, 1, 0, 16'h0001, 0, 0);
        chk(acc_ready, 1'b0, "R2 waiting");
        step(1, 1, 0, 16'h0001, 0, 1);
        chk(acc_ready, 1'b1, "R2 release at strobe");
        step(0, 0, 0, 16'h0, 0, 0);

        // R3: stalled read released at strobe
        step(1, 1, 0, 16'hFF02, 0, 0);
        step(1, 1, 0, 16'hFF02, 0, 1);
        chk(acc_ready, 1'b1, "R3 read released at strobe");
        step(0, 0, 0, 16'h0, 0, 0);

        // R9: drop request while stalled
        step(1, 1, 1, 16'hFF00, 0, 0);
        chk(acc_ready, 1'b0, "R9 stalled");
        step(0, 1, 1, 16'hFF00, 0, 1);
        chk(acc_ready, 1'b0, "R9 dropped request at strobe");
        step(1, 1, 0, 16'h1234, 0, 0);
        chk(acc_ready, 1'b1, "R9 next request judged afresh");
        step(0, 0, 0, 16'h0, 0, 0);

        // R6: colour write waits for buffer
        step(1, 0, 1, 16'hD9AB, 1, 0);
        chk(acc_ready, 1'b0, "R6 busy first cycle");
        step(1, 0, 1, 16'hD9AB, 1, 1);
        chk(acc_ready, 1'b0, "R6 busy, strobe irrelevant");
        step(1, 0, 1, 16'hD9AB, 0, 0);
        chk(acc_ready, 1'b1, "R6 granted when buffer free");
        step(0, 0, 0, 16'h0, 0, 0);

        // R7: lockout after port write granted without strobe
        step(1, 1, 1, 16'hD600, 0, 0);
        chk(acc_ready, 1'b1, "R7 port write granted");
        step(0, 1, 0, 16'h0, 0, 0);
        chk(vdc_lockout, 1'b1, "R7 lockout raised");
        step(0, 1, 0, 16'h0, 0, 1);
        chk(vdc_lockout, 1'b1, "R7 lockout at first strobe");
        step(0, 1, 0, 16'h0, 0, 0);
        chk(vdc_lockout, 1'b1, "R7 lockout whole cycle");
        step(0, 1, 0, 16'h0, 0, 1);
        chk(vdc_lockout, 1'b1, "R7 lockout at second strobe");
        step(0, 1, 0, 16'h0, 0, 0);
        chk(vdc_lockout, 1'b0, "R7 lockout cleared");

        // R8: port read during first part of lockout
        step(1, 1, 1, 16'hD600, 0, 0);
        chk(acc_ready, 1'b1, "R8 setup port write");
        step(1, 1, 0, 16'hD601, 0, 0);
        chk(acc_ready, 1'b0, "R8 port read locked");
        step(1, 1, 0, 16'hD601, 0, 1);
        chk(acc_ready, 1'b0, "R8 refused at first strobe");
        step(1, 1, 0, 16'hD601, 0, 0);
        chk(acc_ready, 1'b0, "R8 still held");
        step(1, 1, 0, 16'hD601, 0, 1);
        chk(acc_ready, 1'b1, "R8 granted at strobe ending lockout");
        step(0, 1, 0, 16'h0, 0, 0);
        chk(vdc_lockout, 1'b1, "R7 lockout after strobe grant");
        step(1, 1, 0, 16'h2000, 0, 0);
        chk(acc_ready, 1'b1, "R8 other address unaffected");
        step(0, 1, 0, 16'h0, 0, 1);
        chk(vdc_lockout, 1'b1, "R7 strobe-grant lockout at strobe");
        step(0, 1, 0, 16'h0, 0, 0);
        chk(vdc_lockout, 1'b0, "R7 strobe-grant lockout cleared");

        // R8: port write during second part of lockout
        step(1, 1, 1, 16'hD601, 0, 0);
        chk(acc_ready, 1'b1, "R8 setup port write 2");
        step(0, 1, 0, 16'h0, 0, 1);
        step(1, 1, 1, 16'hD600, 0, 0);
        chk(acc_ready, 1'b0, "R8 write locked in hold");
        step(1, 1, 1, 16'hD600, 0, 1);
        chk(acc_ready, 1'b1, "R8 write granted at ending strobe");
        step(0, 0, 0, 16'h0, 0, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule